// File: doc/BRIEF.md
# Serial Flash Read DMA Engine

This block moves a contiguous window of serial flash contents into system memory without processor involvement. Software programs three addresses through a small register port: where to begin reading in flash, where the copy should land in memory, and the memory address just past the last byte to be written. Setting the start bit then launches the copy. The amount of data moved follows from the gap between the two memory addresses; there is no separate count register.

While running, the engine pulls bytes one at a time from a flash read sequencer over a valid/request stream and gathers them into 16-byte beats. Each full beat goes out on a simple memory write port with a ready handshake. When the beat ending at the end address has been accepted, the start bit falls back to zero and a done flag in an 8-bit interrupt status register is raised. The interrupt pin follows that flag only when the matching enable bit is set. A run bit in the control register aborts the engine when software writes it to zero. Destination addresses are wider than the 32-bit register port, so each of the two memory addresses has an extra register for its upper bits.

Top module: `flash_rd_dma`

## Requirements
- R1: Registers are selected by word index: 0 control, 1 flash start, 2 destination low, 3 end low, 4 destination high, 5 end high, 6 interrupt status, 7 interrupt enable. The lowest 4 bits of the flash start, destination low and end low registers are dropped on write and read back as 0. The high registers keep only HI_W bits.
- R2: Writing the control register with bit 0 (go) and bit 1 (run) both set while idle starts a transfer. Control bit 0 reads 1 while busy and 0 once the transfer completes. Control bit 1 reads back the run setting.
- R3: While fetching, the engine holds rd_req high with rd_addr equal to the flash address of the next byte. It begins at the aligned flash start, accepts a byte on each cycle where rd_req and rd_valid are both high, and then advances rd_addr by one.
- R4: Bytes are packed in arrival order, with the k-th byte of a beat on mem_wdata bits 8k+7..8k. A beat is presented only after all 16 of its bytes have arrived.
- R5: mem_we stays high with mem_addr and mem_wdata stable until mem_ready. Beats go to the destination start, then to successive addresses 16 apart. Their count is (end - destination)/16.
- R6: If the end address is less than or equal to the destination address, the transfer completes at once. No memory write occurs, control bit 0 reads 0 on the next cycle, and status bit 7 is set.
- R7: Completion sets status bit 7. irq is high exactly when a status bit and its enable bit are both set; with enable bit 7 clear, irq stays low.
- R8: Writing the status register clears each bit written as 1. Bits written as 0 keep their value.
- R9: A start written while a transfer is in progress is ignored, and so are address register changes made during it. The running transfer completes unchanged.
- R10: Writing the control register with bit 1 clear aborts at once. The engine returns to idle, sets no status bit, and issues no further stream requests or memory writes. After run is set again, a new transfer works normally.
- R11: The destination and end addresses are HI_W+32 bits wide, formed as high register over low register. mem_addr carries the full width, including when a transfer crosses a 32-bit boundary.
- R12: After reset the engine is idle: control reads 2 (run set, not busy), status and enable read 0, and irq, rd_req and mem_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| rd_req | output | 1 | Engine wants the next flash byte |
| rd_addr | output | 32 | Flash address of the byte wanted |
| rd_valid | input | 1 | Byte on rd_byte is available |
| rd_byte | input | 8 | Flash byte data |
| mem_we | output | 1 | Memory beat write request |
| mem_addr | output | 36 | Byte address of the beat's first byte |
| mem_wdata | output | 128 | Beat data, first byte in the low lane |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| irq | output | 1 | Interrupt request |

## Verification
The copy path is driven by a table of transfers: a multi-beat copy, a single beat, an equal start and end, an end below the start, a copy whose memory addresses cross a 32-bit boundary, and one with unaligned register values. Together they separate correct beat counting from off-by-one termination, full-width comparison from low-word-only comparison, and alignment masking from raw address use. Throughout, the byte source and the memory sink stall in fixed patterns that do not line up with each other. Every accepted byte is checked against the expected flash address, and every accepted beat against a flash content model at its expected memory address, which exposes lane-order and address-step faults. Directed tests cover masked interrupts, write-one-to-clear, a restart during a copy, and an abort while a beat waits at a stalled sink.

// File: rtl/fdma_pkg.sv
package fdma_pkg;

  localparam int RA_W     = 3;
  localparam int STAT_W   = 8;
  localparam int DONE_BIT = 7;
  localparam int CTRL_GO  = 0;
  localparam int CTRL_RUN = 1;

  typedef enum logic [RA_W-1:0] {
    RA_CTRL   = 3'd0,
    RA_FLASH  = 3'd1,
    RA_DST_LO = 3'd2,
    RA_END_LO = 3'd3,
    RA_DST_HI = 3'd4,
    RA_END_HI = 3'd5,
    RA_ISTAT  = 3'd6,
    RA_IEN    = 3'd7
  } fdma_reg_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } fdma_state_e;

  // Nothing to copy when the end does not lie past the start.
  function automatic logic f_range_empty(input logic [63:0] start_a,
                                         input logic [63:0] end_a);
    return end_a <= start_a;
  endfunction

  // The beat at cur_a is the final one when the next beat would reach end_a.
  function automatic logic f_last_beat(input logic [63:0] cur_a,
                                       input logic [63:0] end_a,
                                       input logic [63:0] beat_sz);
    return (cur_a + beat_sz) >= end_a;
  endfunction

  // Write-one-to-clear status update; a hardware set wins over a clear.
  function automatic logic [STAT_W-1:0] f_stat_next(input logic [STAT_W-1:0] cur,
                                                    input logic [STAT_W-1:0] clr,
                                                    input logic              set_done);
    logic [STAT_W-1:0] nxt;
    nxt = cur & ~clr;
    if (set_done) nxt[DONE_BIT] = 1'b1;
    return nxt;
  endfunction

endpackage

// File: rtl/fdma_regs.sv
module fdma_regs
  import fdma_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int HI_W       = 4,
  parameter int BEAT_BYTES = 16,
  parameter int DST_W      = REG_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   reg_sel,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              busy,
  input  logic              done_evt,
  output logic              go,
  output logic              eng_clr,
  output logic [REG_W-1:0]  flash_addr,
  output logic [DST_W-1:0]  dst_addr,
  output logic [DST_W-1:0]  end_addr,
  output logic [STAT_W-1:0] istat,
  output logic              irq
);

  localparam logic [REG_W-1:0] ALIGN_M = REG_W'(BEAT_BYTES - 1);

  fdma_reg_e ra;
  assign ra = fdma_reg_e'(reg_sel);

  logic              run_q;
  logic [REG_W-1:0]  fl_q, dlo_q, elo_q;
  logic [HI_W-1:0]   dhi_q, ehi_q;
  logic [STAT_W-1:0] istat_q, ien_q;

  logic wr_ctrl, wr_istat;
  assign wr_ctrl  = wr_en && (ra == RA_CTRL);
  assign wr_istat = wr_en && (ra == RA_ISTAT);
  assign go       = wr_ctrl && wr_data[CTRL_GO] && wr_data[CTRL_RUN];
  assign eng_clr  = wr_ctrl && !wr_data[CTRL_RUN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b1;
      fl_q    <= '0;
      dlo_q   <= '0;
      elo_q   <= '0;
      dhi_q   <= '0;
      ehi_q   <= '0;
      ien_q   <= '0;
      istat_q <= '0;
    end else begin
      if (wr_ctrl) run_q <= wr_data[CTRL_RUN];
      if (wr_en && ra == RA_FLASH)  fl_q  <= wr_data & ~ALIGN_M;
      if (wr_en && ra == RA_DST_LO) dlo_q <= wr_data & ~ALIGN_M;
      if (wr_en && ra == RA_END_LO) elo_q <= wr_data & ~ALIGN_M;
      if (wr_en && ra == RA_DST_HI) dhi_q <= wr_data[HI_W-1:0];
      if (wr_en && ra == RA_END_HI) ehi_q <= wr_data[HI_W-1:0];
      if (wr_en && ra == RA_IEN)    ien_q <= wr_data[STAT_W-1:0];
      istat_q <= f_stat_next(istat_q,
                             wr_istat ? wr_data[STAT_W-1:0] : '0,
                             done_evt);
    end
  end

  always_comb begin
    rd_data = '0;
    case (ra)
      RA_CTRL:   rd_data = {{(REG_W-2){1'b0}}, run_q, busy};
      RA_FLASH:  rd_data = fl_q;
      RA_DST_LO: rd_data = dlo_q;
      RA_END_LO: rd_data = elo_q;
      RA_DST_HI: rd_data = REG_W'(dhi_q);
      RA_END_HI: rd_data = REG_W'(ehi_q);
      RA_ISTAT:  rd_data = REG_W'(istat_q);
      RA_IEN:    rd_data = REG_W'(ien_q);
      default:   rd_data = '0;
    endcase
  end

  assign flash_addr = fl_q;
  assign dst_addr   = {dhi_q, dlo_q};
  assign end_addr   = {ehi_q, elo_q};
  assign istat      = istat_q;
  assign irq        = |(istat_q & ien_q);

endmodule

// File: rtl/fdma_packer.sv
module fdma_packer #(
  parameter int BEAT_BYTES = 16,
  parameter int DATA_W     = BEAT_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [7:0]        din,
  output logic [DATA_W-1:0] beat,
  output logic              last_byte
);

  localparam int CNT_W = (BEAT_BYTES > 1) ? $clog2(BEAT_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEAT_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last_byte = take && (cnt_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clr)       cnt_q <= '0;
    else if (last_byte) cnt_q <= '0;
    else if (take)      cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 0; k < BEAT_BYTES; k++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               lane_q <= '0;
      else if (take && cnt_q == CNT_W'(k))      lane_q <= din;
    end
    assign beat[8*k +: 8] = lane_q;
  end

endmodule

// File: rtl/fdma_ctrl.sv
module fdma_ctrl
  import fdma_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int DST_W      = 36,
  parameter int BEAT_BYTES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             eng_clr,
  input  logic [REG_W-1:0] flash_addr,
  input  logic [DST_W-1:0] dst_addr,
  input  logic [DST_W-1:0] end_addr,
  input  logic             byte_valid,
  input  logic             last_byte,
  input  logic             mem_ready,
  output logic             take,
  output logic             pack_clr,
  output logic             stream_req,
  output logic [REG_W-1:0] stream_addr,
  output logic             mem_we,
  output logic [DST_W-1:0] mem_addr,
  output logic             busy,
  output logic             done_evt
);

  localparam logic [DST_W-1:0] BEAT_STEP = DST_W'(BEAT_BYTES);

  fdma_state_e      state_q;
  logic [REG_W-1:0] cur_fl_q;
  logic [DST_W-1:0] cur_dst_q, end_q;

  logic go_acc, empty_req, final_beat, beat_done;

  assign go_acc     = go && !eng_clr && (state_q == ST_IDLE);
  assign empty_req  = f_range_empty(64'(dst_addr), 64'(end_addr));
  assign final_beat = f_last_beat(64'(cur_dst_q), 64'(end_q), 64'(BEAT_BYTES));
  assign beat_done  = (state_q == ST_WRITE) && mem_ready;

  assign take       = (state_q == ST_FILL) && byte_valid;
  assign pack_clr   = eng_clr || go_acc;
  assign stream_req = (state_q == ST_FILL);
  assign stream_addr = cur_fl_q;
  assign mem_we     = (state_q == ST_WRITE);
  assign mem_addr   = cur_dst_q;
  assign busy       = (state_q != ST_IDLE);
  assign done_evt   = !eng_clr && ((go_acc && empty_req) || (beat_done && final_beat));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_fl_q  <= '0;
      cur_dst_q <= '0;
      end_q     <= '0;
    end else if (eng_clr) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (go_acc) begin
            cur_fl_q  <= flash_addr;
            cur_dst_q <= dst_addr;
            end_q     <= end_addr;
            state_q   <= empty_req ? ST_IDLE : ST_FILL;
          end
        end
        ST_FILL: begin
          if (take) begin
            cur_fl_q <= cur_fl_q + 1'b1;
            if (last_byte) state_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (mem_ready) begin
            cur_dst_q <= cur_dst_q + BEAT_STEP;
            state_q   <= final_beat ? ST_IDLE : ST_FILL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_rd_dma.sv
module flash_rd_dma
  import fdma_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int HI_W       = 4,
  parameter int BEAT_BYTES = 16,
  parameter int DST_W      = REG_W + HI_W,
  parameter int DATA_W     = BEAT_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              rd_req,
  output logic [REG_W-1:0]  rd_addr,
  input  logic              rd_valid,
  input  logic [7:0]        rd_byte,
  output logic              mem_we,
  output logic [DST_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  output logic              irq
);

  // Named internal events, also observed by the bound checker.
  logic              eng_go, eng_clr, eng_busy, eng_done;
  logic              take_w, last_byte_w, pack_clr_w;
  logic [REG_W-1:0]  flash_w;
  logic [DST_W-1:0]  dst_w, end_w;
  logic [STAT_W-1:0] istat_w;

  fdma_regs #(
    .REG_W(REG_W), .HI_W(HI_W), .BEAT_BYTES(BEAT_BYTES), .DST_W(DST_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_we), .reg_sel(reg_addr), .wr_data(reg_wdata), .rd_data(reg_rdata),
    .busy(eng_busy), .done_evt(eng_done),
    .go(eng_go), .eng_clr(eng_clr),
    .flash_addr(flash_w), .dst_addr(dst_w), .end_addr(end_w),
    .istat(istat_w), .irq(irq)
  );

  fdma_ctrl #(
    .REG_W(REG_W), .DST_W(DST_W), .BEAT_BYTES(BEAT_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .go(eng_go), .eng_clr(eng_clr),
    .flash_addr(flash_w), .dst_addr(dst_w), .end_addr(end_w),
    .byte_valid(rd_valid), .last_byte(last_byte_w), .mem_ready(mem_ready),
    .take(take_w), .pack_clr(pack_clr_w),
    .stream_req(rd_req), .stream_addr(rd_addr),
    .mem_we(mem_we), .mem_addr(mem_addr),
    .busy(eng_busy), .done_evt(eng_done)
  );

  fdma_packer #(
    .BEAT_BYTES(BEAT_BYTES), .DATA_W(DATA_W)
  ) u_pack (
    .clk(clk), .rst_n(rst_n),
    .clr(pack_clr_w), .take(take_w), .din(rd_byte),
    .beat(mem_wdata), .last_byte(last_byte_w)
  );

endmodule

// File: rtl/fdma_chk.sv
module fdma_chk
  import fdma_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int DST_W      = 36,
  parameter int BEAT_BYTES = 16,
  parameter int DATA_W     = BEAT_BYTES * 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [REG_W-1:0]  rd_addr,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [DST_W-1:0]  mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              irq,
  input logic              busy,
  input logic              done_evt,
  input logic              eng_clr,
  input logic [STAT_W-1:0] istat
);

  localparam int BEAT_LG = (BEAT_BYTES > 1) ? $clog2(BEAT_BYTES) : 1;

  a_r5_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !mem_ready && !eng_clr |=> mem_we && $stable(mem_addr) && $stable(mem_wdata));

  a_r5_beat_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[BEAT_LG-1:0] == '0));

  a_r3_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid && !eng_clr |=> rd_req && $stable(rd_addr));

  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_valid && !eng_clr |=> !rd_req || ((rd_addr - $past(rd_addr)) == REG_W'(1)));

  a_r4_fetch_or_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && mem_we));

  a_r7_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> istat[DONE_BIT]);

  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> istat[DONE_BIT]);

  a_r2_finish_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(eng_clr) |-> istat[DONE_BIT]);

  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    eng_clr |=> !busy && !mem_we && !rd_req);

endmodule

bind flash_rd_dma fdma_chk #(
  .REG_W(REG_W), .DST_W(DST_W), .BEAT_BYTES(BEAT_BYTES), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_req(rd_req), .rd_valid(rd_valid), .rd_addr(rd_addr),
  .mem_we(mem_we), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .irq(irq), .busy(eng_busy), .done_evt(eng_done), .eng_clr(eng_clr), .istat(istat_w)
);

// File: tb/tb_flash_rd_dma.sv
module tb_flash_rd_dma;

  localparam int DST_W  = 36;
  localparam int DATA_W = 128;
  localparam logic [2:0] A_CTRL = 3'd0, A_FL = 3'd1, A_DLO = 3'd2, A_ELO = 3'd3,
                         A_DHI = 3'd4, A_EHI = 3'd5, A_IST = 3'd6, A_IEN = 3'd7;

  // Transfer table: flash start, dest low/high, end low/high, expected beats.
  localparam int NV = 6;
  localparam logic [31:0] T_FL  [NV] = '{32'h0000_0100, 32'h0000_1230, 32'h0000_03F0,
                                         32'h0000_0040, 32'h0000_1237, 32'h0000_0800};
  localparam logic [31:0] T_DLO [NV] = '{32'h0000_2000, 32'h8000_0000, 32'h0000_0100,
                                         32'hFFFF_FFF0, 32'h0000_0205, 32'h0000_0500};
  localparam logic [31:0] T_DHI [NV] = '{32'd0, 32'd0, 32'd0, 32'd2, 32'd0, 32'd1};
  localparam logic [31:0] T_ELO [NV] = '{32'h0000_2040, 32'h8000_0010, 32'h0000_0100,
                                         32'h0000_0020, 32'h0000_022F, 32'h0000_0400};
  localparam logic [31:0] T_EHI [NV] = '{32'd0, 32'd0, 32'd0, 32'd3, 32'd0, 32'd1};
  localparam int          T_NB  [NV] = '{4, 1, 0, 3, 2, 0};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              rd_req;
  logic [31:0]       rd_addr;
  logic              rd_valid = 1'b0;
  logic [7:0]        rd_byte = '0;
  logic              mem_we;
  logic [DST_W-1:0]  mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_ready = 1'b0;
  logic              irq;

  always #4 clk = ~clk;

  flash_rd_dma dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int beats = 0;
  int fed = 0;
  logic sink_hold = 1'b0;
  logic [31:0] exp_fl = '0;
  logic [DST_W-1:0] exp_dst = '0;
  logic [DATA_W-1:0] exp_beat;
  logic [31:0] rv;

  function automatic logic [7:0] fmod(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Byte source and memory sink, driven and sampled at the falling edge.
  always @(negedge clk) begin
    cyc++;
    rd_valid  = (cyc % 3) != 1;
    rd_byte   = fmod(rd_addr);
    mem_ready = !sink_hold && ((cyc % 4) != 0);
    if (rst_n && rd_req && rd_valid) begin
      chk("R3", "stream address", DATA_W'(rd_addr), DATA_W'(exp_fl + 32'(fed)));
      fed++;
    end
    if (rst_n && mem_we && mem_ready) begin
      for (int k = 0; k < 16; k++) exp_beat[8*k +: 8] = fmod(exp_fl + 32'(beats*16 + k));
      chk("R4", "beat data", mem_wdata, exp_beat);
      chk("R5", "beat address", DATA_W'(mem_addr), DATA_W'(exp_dst + DST_W'(beats*16)));
      beats++;
    end
    if (cyc == 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=finish", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic start_xfer(input logic [31:0] fl, input logic [31:0] dlo, input logic [31:0] dhi,
                            input logic [31:0] elo, input logic [31:0] ehi);
    exp_fl  = fl & ~32'hF;
    exp_dst = {dhi[3:0], dlo} & ~36'hF;
    beats = 0;
    fed = 0;
    wr(A_FL, fl); wr(A_DLO, dlo); wr(A_DHI, dhi); wr(A_ELO, elo); wr(A_EHI, ehi);
    wr(A_CTRL, 32'h3);
  endtask

  task automatic wait_irq(input string rq);
    int n = 0;
    while (!irq && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(rq, "completion interrupt", DATA_W'(irq), DATA_W'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12: reset state
    rd(A_CTRL, rv); chk("R12", "ctrl after reset", DATA_W'(rv), DATA_W'(2));
    rd(A_IST, rv);  chk("R12", "status after reset", DATA_W'(rv), DATA_W'(0));
    rd(A_IEN, rv);  chk("R12", "enable after reset", DATA_W'(rv), DATA_W'(0));
    chk("R12", "irq after reset", DATA_W'(irq), DATA_W'(0));
    chk("R12", "rd_req after reset", DATA_W'(rd_req), DATA_W'(0));
    chk("R12", "mem_we after reset", DATA_W'(mem_we), DATA_W'(0));

    // R1: readback and masking
    wr(A_FL, 32'h0000_1237);  rd(A_FL, rv);  chk("R1", "flash low bits", DATA_W'(rv), DATA_W'(32'h1230));
    wr(A_DHI, 32'h0000_00FF); rd(A_DHI, rv); chk("R1", "dest high width", DATA_W'(rv), DATA_W'(32'hF));
    wr(A_ELO, 32'h0000_ABCD); rd(A_ELO, rv); chk("R1", "end low bits", DATA_W'(rv), DATA_W'(32'hABC0));
    wr(A_IEN, 32'h0000_0080); rd(A_IEN, rv); chk("R1", "enable readback", DATA_W'(rv), DATA_W'(32'h80));

    // Table of transfers: R2, R5, R6, R11
    for (int i = 0; i < NV; i++) begin
      start_xfer(T_FL[i], T_DLO[i], T_DHI[i], T_ELO[i], T_EHI[i]);
      rd(A_CTRL, rv);
      if (T_NB[i] == 0) begin
        chk("R6", "empty range not busy", DATA_W'(rv), DATA_W'(2));
        rd(A_IST, rv);
        chk("R6", "empty range sets flag", DATA_W'(rv), DATA_W'(32'h80));
      end else begin
        chk("R2", "busy while copying", DATA_W'(rv), DATA_W'(3));
      end
      wait_irq("R7");
      chk(T_NB[i] == 0 ? "R6" : (T_DHI[i] != T_EHI[i] ? "R11" : "R5"),
          "beat count", DATA_W'(beats), DATA_W'(T_NB[i]));
      rd(A_CTRL, rv); chk("R2", "start bit clears", DATA_W'(rv), DATA_W'(2));
      rd(A_IST, rv);  chk("R7", "done flag", DATA_W'(rv), DATA_W'(32'h80));
      wr(A_IST, 32'h80);
      rd(A_IST, rv);  chk("R8", "flag cleared", DATA_W'(rv), DATA_W'(0));
      chk("R7", "irq drops", DATA_W'(irq), DATA_W'(0));
    end

    // R7 masked interrupt and R8 write-one-to-clear
    wr(A_IEN, 32'h0);
    start_xfer(32'h0000_0300, 32'h0000_1000, 32'h0, 32'h0000_1010, 32'h0);
    for (int n = 0; n < 2000; n++) begin
      rd(A_CTRL, rv);
      if (rv[0] == 1'b0) break;
    end
    chk("R7", "masked irq low", DATA_W'(irq), DATA_W'(0));
    rd(A_IST, rv); chk("R7", "flag set while masked", DATA_W'(rv), DATA_W'(32'h80));
    wr(A_IEN, 32'h80);
    chk("R7", "irq on enable", DATA_W'(irq), DATA_W'(1));
    wr(A_IST, 32'h7F);
    rd(A_IST, rv); chk("R8", "zero bit keeps flag", DATA_W'(rv), DATA_W'(32'h80));
    wr(A_IST, 32'h80);
    rd(A_IST, rv); chk("R8", "one bit clears flag", DATA_W'(rv), DATA_W'(0));

    // R9: restart during transfer is ignored
    start_xfer(32'h0000_0600, 32'h0000_3000, 32'h0, 32'h0000_3020, 32'h0);
    wr(A_FL, 32'h0000_0900); wr(A_DLO, 32'h0000_7000); wr(A_ELO, 32'h0000_7100);
    wr(A_CTRL, 32'h3);
    wait_irq("R9");
    chk("R9", "original beat count", DATA_W'(beats), DATA_W'(2));
    wr(A_IST, 32'h80);
    repeat (20) @(negedge clk);
    chk("R9", "no second transfer", DATA_W'(beats), DATA_W'(2));
    rd(A_CTRL, rv); chk("R9", "idle after ignored start", DATA_W'(rv), DATA_W'(2));

    // R10: abort while a beat waits at a stalled sink
    sink_hold = 1'b1;
    start_xfer(32'h0000_0A00, 32'h0000_4000, 32'h0, 32'h0000_4040, 32'h0);
    for (int n = 0; n < 500 && !mem_we; n++) @(negedge clk);
    chk("R10", "beat pending before abort", DATA_W'(mem_we), DATA_W'(1));
    wr(A_CTRL, 32'h0);
    chk("R10", "mem_we after abort", DATA_W'(mem_we), DATA_W'(0));
    chk("R10", "rd_req after abort", DATA_W'(rd_req), DATA_W'(0));
    rd(A_CTRL, rv); chk("R10", "ctrl after abort", DATA_W'(rv), DATA_W'(0));
    sink_hold = 1'b0;
    repeat (30) @(negedge clk);
    chk("R10", "no beat after abort", DATA_W'(beats), DATA_W'(0));
    rd(A_IST, rv); chk("R10", "no flag after abort", DATA_W'(rv), DATA_W'(0));
    wr(A_CTRL, 32'h2);
    rd(A_CTRL, rv); chk("R10", "run set again", DATA_W'(rv), DATA_W'(2));
    start_xfer(32'h0000_0B00, 32'h0000_5000, 32'h0, 32'h0000_5010, 32'h0);
    wait_irq("R10");
    chk("R10", "transfer after rerun", DATA_W'(beats), DATA_W'(1));

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule